// File: doc/BRIEF.md
# Sync mode-change detector

This block watches a horizontal and a vertical sync input and raises a sticky mute flag when the video timing changes. Each sync input is synchronized and its rising edges are found. The horizontal line length is measured in reference clocks. The vertical frame length is measured in lines.

Three detection sources can set the flag, and each has its own active-low enable:
- A jump in line length larger than a 4-bit programmable threshold.
- A change in the majority level of either sync.
- Saturation of either period counter.

While the flag is set and the interrupt is unmasked, a non-maskable interrupt request is driven. Software configures the block through two write strobes that share a 4-bit data bus. It clears the flag with a one-cycle clear strobe.

Top module: `sync_change_detect`

## Requirements
- R1: After reset, muteFlag, nmiReq, hPeriod and vPeriod are 0. All three detection sources are disabled, the interrupt is masked and the threshold is 15.
- R2: hPeriod holds the number of clock cycles between the two most recent rising edges of the synchronized hsyncIn. vPeriod holds the number of hsync rising edges between the two most recent vsync rising edges.
- R3: enWe loads cfgData into four enables: bit0 deltaOff, bit1 polOff, bit2 ovfOff, bit3 irqEn. thrWe loads cfgData[3:0] into the threshold. With deltaOff=0, a new line length whose absolute difference from the previous one is greater than the threshold sets muteFlag. A difference equal to or below the threshold does not.
- R4: The first line measurement after the delta check is enabled only primes the comparison and never sets muteFlag.
- R5: Each sync channel takes one polarity sample per period: 1 when the line was high for more than half the period. With polOff=0, two successive samples that differ on either channel set muteFlag.
- R6: The horizontal counter saturates at 2^H_W-1 clocks without an hsync edge, and the vertical counter at 2^V_W-1 lines without a vsync edge. With ovfOff=0, reaching saturation sets muteFlag. A saturated line reports hPeriod = 2^H_W-1.
- R7: A source whose disable bit is 1 never sets muteFlag.
- R8: muteFlag stays set until muteClr is 1. A set event in the same cycle as muteClr leaves the flag set.
- R9: nmiReq is 1 exactly while muteFlag is 1 and irqEn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncIn | input | 1 | Horizontal sync, asynchronous |
| vsyncIn | input | 1 | Vertical sync, asynchronous |
| enWe | input | 1 | Write strobe for the enable bits |
| thrWe | input | 1 | Write strobe for the threshold |
| cfgData | input | 4 | Write data for enWe and thrWe |
| muteClr | input | 1 | Clears muteFlag when 1 |
| muteFlag | output | 1 | Sticky mode-change flag |
| nmiReq | output | 1 | Non-maskable interrupt request |
| hPeriod | output | H_W | Last measured line length in clocks |
| vPeriod | output | V_W | Last measured frame length in lines |

## Verification
The assertions take for granted that the write strobes and muteClr are single-cycle, synchronous pulses. They also assume that each sync level is held for at least two reference clocks, so the synchronizer never misses a pulse. The bench drives every input on the falling clock edge and keeps sync pulses two clocks wide with lines of at least eight clocks. It changes vsync only together with an hsync rising edge, which keeps the frame length an exact line count.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;
  localparam int THR_W = 4;

  // strobes from the measuring datapath to the control
  typedef struct packed {
    logic hMeasured;
    logic deltaBig;
    logic hPolFlip;
    logic vPolFlip;
    logic hOvf;
    logic vOvf;
  } syncdet_obs_t;

  typedef struct packed {
    logic             irqEn;
    logic             ovfOff;
    logic             polOff;
    logic             deltaOff;
    logic [THR_W-1:0] thresh;
  } syncdet_cfg_t;

  localparam syncdet_cfg_t CFG_RESET = '{
    irqEn: 1'b0, ovfOff: 1'b1, polOff: 1'b1, deltaOff: 1'b1, thresh: '1
  };
endpackage

// File: rtl/syncdet_chan.sv
module syncdet_chan #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rawIn,
  input  logic         tick,
  output logic         edgeOut,
  output logic         flip,
  output logic         ovf,
  output logic [W-1:0] period
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_PRE = CNT_MAX - 1'b1;

  logic [1:0]   syncQ;
  logic         prevQ;
  logic         lvl;
  logic [W-1:0] cnt;
  logic [W-1:0] high;
  logic         polQ;
  logic         polValid;
  logic         maj;

  assign lvl     = syncQ[1];
  assign edgeOut = lvl & ~prevQ;
  assign maj     = {high, 1'b0} > {1'b0, cnt};
  assign flip    = edgeOut & polValid & (maj ^ polQ);
  assign ovf     = tick & ~edgeOut & (cnt == CNT_PRE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      prevQ    <= 1'b0;
      cnt      <= '0;
      high     <= '0;
      period   <= '0;
      polQ     <= 1'b0;
      polValid <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      prevQ <= lvl;
      if (edgeOut) begin
        cnt      <= {{(W-1){1'b0}}, tick};
        high     <= {{(W-1){1'b0}}, tick};
        period   <= cnt;
        polQ     <= maj;
        polValid <= 1'b1;
      end else if (tick) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (lvl && high != CNT_MAX) high <= high + 1'b1;
      end
    end
  end
endmodule

// File: rtl/syncdet_datapath.sv
module syncdet_datapath
  import syncdet_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic [THR_W-1:0] thresh,
  output syncdet_obs_t     obs,
  output logic [H_W-1:0]   hPeriod,
  output logic [V_W-1:0]   vPeriod
);
  logic           hEdge;
  logic           vEdgeUnq;
  logic           hFlip;
  logic           vFlip;
  logic           hOvf;
  logic           vOvf;
  logic           hEdgeD;
  logic [H_W-1:0] hPrevPeriod;
  logic [H_W-1:0] diff;

  syncdet_chan #(.W(H_W)) uHoriz (
    .clk(clk), .rstN(rstN), .rawIn(hsyncIn), .tick(1'b1),
    .edgeOut(hEdge), .flip(hFlip), .ovf(hOvf), .period(hPeriod)
  );

  syncdet_chan #(.W(V_W)) uVert (
    .clk(clk), .rstN(rstN), .rawIn(vsyncIn), .tick(hEdge),
    .edgeOut(vEdgeUnq), .flip(vFlip), .ovf(vOvf), .period(vPeriod)
  );

  // compare one cycle after the edge, once the new period is latched
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hEdgeD      <= 1'b0;
      hPrevPeriod <= '0;
    end else begin
      hEdgeD <= hEdge;
      if (hEdge) hPrevPeriod <= hPeriod;
    end
  end

  assign diff = (hPeriod >= hPrevPeriod) ? hPeriod - hPrevPeriod
                                         : hPrevPeriod - hPeriod;

  always_comb begin
    obs           = '0;
    obs.hMeasured = hEdgeD;
    obs.deltaBig  = hEdgeD & (diff > {{(H_W-THR_W){1'b0}}, thresh});
    obs.hPolFlip  = hFlip;
    obs.vPolFlip  = vFlip & vEdgeUnq;
    obs.hOvf      = hOvf;
    obs.vOvf      = vOvf;
  end
endmodule

// File: rtl/syncdet_control.sv
module syncdet_control
  import syncdet_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWe,
  input  logic             thrWe,
  input  logic [THR_W-1:0] cfgData,
  input  logic             muteClr,
  input  syncdet_obs_t     obs,
  output syncdet_cfg_t     cfgQ,
  output logic             armed,
  output logic             muteFlag,
  output logic             nmiReq
);
  logic deltaEvt;
  logic polEvt;
  logic ovfEvt;
  logic setEvt;

  assign deltaEvt = ~cfgQ.deltaOff & armed & obs.deltaBig;
  assign polEvt   = ~cfgQ.polOff & (obs.hPolFlip | obs.vPolFlip);
  assign ovfEvt   = ~cfgQ.ovfOff & (obs.hOvf | obs.vOvf);
  assign setEvt   = deltaEvt | polEvt | ovfEvt;
  assign nmiReq   = muteFlag & cfgQ.irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ     <= CFG_RESET;
      armed    <= 1'b0;
      muteFlag <= 1'b0;
    end else begin
      if (enWe) {cfgQ.irqEn, cfgQ.ovfOff, cfgQ.polOff, cfgQ.deltaOff} <= cfgData;
      if (thrWe) cfgQ.thresh <= cfgData;
      if (cfgQ.deltaOff)      armed <= 1'b0;
      else if (obs.hMeasured) armed <= 1'b1;
      muteFlag <= setEvt | (muteFlag & ~muteClr);
    end
  end
endmodule

// File: rtl/sync_change_detect.sv
module sync_change_detect
  import syncdet_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic             enWe,
  input  logic             thrWe,
  input  logic [THR_W-1:0] cfgData,
  input  logic             muteClr,
  output logic             muteFlag,
  output logic             nmiReq,
  output logic [H_W-1:0]   hPeriod,
  output logic [V_W-1:0]   vPeriod
);
  syncdet_obs_t obs;
  syncdet_cfg_t cfgQ;
  logic         armed;

  syncdet_datapath #(.H_W(H_W), .V_W(V_W)) uDp (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .thresh(cfgQ.thresh), .obs(obs), .hPeriod(hPeriod), .vPeriod(vPeriod)
  );

  syncdet_control uCtl (
    .clk(clk), .rstN(rstN), .enWe(enWe), .thrWe(thrWe), .cfgData(cfgData),
    .muteClr(muteClr), .obs(obs), .cfgQ(cfgQ), .armed(armed),
    .muteFlag(muteFlag), .nmiReq(nmiReq)
  );
endmodule

// File: rtl/syncdet_chk.sv
module syncdet_chk (
  input logic clk,
  input logic rstN,
  input logic muteFlag,
  input logic muteClr,
  input logic nmiReq,
  input logic deltaOff,
  input logic polOff,
  input logic ovfOff,
  input logic armed,
  input logic deltaBig,
  input logic hPolFlip,
  input logic vPolFlip,
  input logic hOvf,
  input logic vOvf
);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    muteFlag && !muteClr |=> muteFlag);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hOvf || vOvf) && !ovfOff |=> muteFlag);

  // R5
  pol_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hPolFlip || vPolFlip) && !polOff |=> muteFlag);

  // R3
  delta_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    deltaBig && armed && !deltaOff |=> muteFlag);

  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    deltaOff && polOff && ovfOff && !muteFlag |=> !muteFlag);

  // R4
  arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    deltaOff |=> !armed);

  // R9
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> muteFlag);
endmodule

bind sync_change_detect syncdet_chk uChk (
  .clk(clk), .rstN(rstN), .muteFlag(muteFlag), .muteClr(muteClr),
  .nmiReq(nmiReq), .deltaOff(cfgQ.deltaOff), .polOff(cfgQ.polOff),
  .ovfOff(cfgQ.ovfOff), .armed(armed), .deltaBig(obs.deltaBig),
  .hPolFlip(obs.hPolFlip), .vPolFlip(obs.vPolFlip), .hOvf(obs.hOvf),
  .vOvf(obs.vOvf)
);

// File: tb/tb_sync_change_detect.sv
module tb_sync_change_detect;
  localparam int CLK_PERIOD = 10;
  localparam int H_W = 12;
  localparam int V_W = 11;
  localparam int H_SAT = (1 << H_W) - 1;

  // {threshold, old period, new period, expected flag}
  localparam logic [31:0] VEC [0:8] = '{
    {8'd4,  8'd20, 8'd24, 8'd0},
    {8'd4,  8'd20, 8'd25, 8'd1},
    {8'd4,  8'd25, 8'd20, 8'd1},
    {8'd0,  8'd30, 8'd30, 8'd0},
    {8'd0,  8'd30, 8'd31, 8'd1},
    {8'd15, 8'd40, 8'd55, 8'd0},
    {8'd15, 8'd40, 8'd56, 8'd1},
    {8'd7,  8'd16, 8'd9,  8'd0},
    {8'd7,  8'd16, 8'd8,  8'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncIn = 1'b0;
  logic vsyncIn = 1'b0;
  logic enWe = 1'b0;
  logic thrWe = 1'b0;
  logic [3:0] cfgData = '0;
  logic muteClr = 1'b0;
  logic muteFlag;
  logic nmiReq;
  logic [H_W-1:0] hPeriod;
  logic [V_W-1:0] vPeriod;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_change_detect #(.H_W(H_W), .V_W(V_W)) dut (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .enWe(enWe), .thrWe(thrWe), .cfgData(cfgData), .muteClr(muteClr),
    .muteFlag(muteFlag), .nmiReq(nmiReq), .hPeriod(hPeriod), .vPeriod(vPeriod)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one line: high for hi cycles then low; act 1 = clear at index at,
  // act 2 = enable only the delta check at index at
  task automatic sendLine(int per, int hi, int act, int at);
    for (int i = 0; i < per; i++) begin
      hsyncIn = (i < hi);
      if (act == 1 && i == at) muteClr = 1'b1;
      if (act == 2 && i == at) begin enWe = 1'b1; cfgData = 4'b0110; end
      @(negedge clk);
      muteClr = 1'b0;
      enWe = 1'b0;
    end
  endtask

  task automatic sendFrame(int lines, int hiLines, int per);
    for (int l = 0; l < lines; l++) begin
      vsyncIn = (l < hiLines);
      sendLine(per, 2, 0, 0);
    end
  endtask

  task automatic writeEn(logic [3:0] v);
    enWe = 1'b1; cfgData = v;
    @(negedge clk);
    enWe = 1'b0;
  endtask

  task automatic writeThr(logic [3:0] v);
    thrWe = 1'b1; cfgData = v;
    @(negedge clk);
    thrWe = 1'b0;
  endtask

  task automatic clearPulse();
    muteClr = 1'b1;
    @(negedge clk);
    muteClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flag", muteFlag, 0);
    check("R1 nmi", nmiReq, 0);
    check("R1 hPeriod", hPeriod, 0);
    check("R1 vPeriod", vPeriod, 0);

    // R1: all sources off after reset
    sendLine(20, 2, 0, 0); sendLine(20, 2, 0, 0);
    sendLine(60, 40, 0, 0); sendLine(60, 40, 0, 0);
    sendLine(20, 2, 0, 0); sendLine(20, 2, 0, 0);
    check("R1 sources disabled", muteFlag, 0);

    // R1: threshold is 15 without any threshold write
    writeEn(4'b0110);
    for (int k = 0; k < 2; k++) begin
      sendLine(30, 2, 0, 0); sendLine(30, 2, 0, 0); sendLine(30, 2, 1, 5);
      for (int j = 0; j < 3; j++) sendLine(45 + k, 2, 0, 0);
      check("R1 default threshold", muteFlag, k);
    end

    // R3 / R2 vector table
    foreach (VEC[v]) begin
      writeThr(VEC[v][27:24]);
      sendLine(int'(VEC[v][23:16]), 2, 0, 0);
      sendLine(int'(VEC[v][23:16]), 2, 0, 0);
      sendLine(int'(VEC[v][23:16]), 2, 1, 5);
      for (int j = 0; j < 3; j++) sendLine(int'(VEC[v][15:8]), 2, 0, 0);
      check("R3 delta vs threshold", muteFlag, int'(VEC[v][7:0]));
      check("R2 hPeriod", hPeriod, int'(VEC[v][15:8]));
    end

    // R4: first measurement after enabling only primes
    writeThr(4'd2);
    writeEn(4'b0111);
    clearPulse();
    sendLine(20, 2, 0, 0); sendLine(20, 2, 0, 0);
    sendLine(40, 2, 2, 5);
    sendLine(40, 2, 0, 0); sendLine(40, 2, 0, 0);
    check("R4 priming", muteFlag, 0);

    // R5: vertical polarity
    writeEn(4'b0101);
    clearPulse();
    sendFrame(6, 1, 8); sendFrame(6, 1, 8); sendFrame(6, 1, 8);
    check("R5 steady vsync", muteFlag, 0);
    check("R2 vPeriod", vPeriod, 6);
    sendFrame(6, 5, 8); sendFrame(6, 5, 8);
    check("R5 vsync flip", muteFlag, 1);

    // R5: horizontal polarity
    clearPulse();
    sendLine(12, 2, 0, 0); sendLine(12, 2, 0, 0); sendLine(12, 2, 0, 0);
    check("R5 steady hsync", muteFlag, 0);
    sendLine(12, 10, 0, 0); sendLine(12, 10, 0, 0);
    check("R5 hsync flip", muteFlag, 1);

    // R7: every source disabled
    writeEn(4'b0111);
    clearPulse();
    sendLine(20, 2, 0, 0); sendLine(60, 2, 0, 0);
    sendLine(4100, 2, 0, 0); sendLine(10, 2, 0, 0);
    check("R7 disabled ignored", muteFlag, 0);

    // R6 / R8: horizontal saturation coincides with a clear
    writeEn(4'b0011);
    clearPulse();
    sendLine(4100, 2, 1, 4096);
    check("R8 set beats clear", muteFlag, 1);
    check("R9 masked", nmiReq, 0);
    writeEn(4'b1011);
    check("R9 unmasked", nmiReq, 1);
    sendLine(10, 2, 0, 0);
    check("R6 saturated hPeriod", hPeriod, H_SAT);
    clearPulse();
    check("R8 clear", muteFlag, 0);
    check("R9 clear", nmiReq, 0);

    // R6: vertical saturation
    sendFrame(2, 1, 8);
    clearPulse();
    for (int j = 0; j < 2000; j++) sendLine(8, 2, 0, 0);
    check("R6 below v limit", muteFlag, 0);
    for (int j = 0; j < 60; j++) sendLine(8, 2, 0, 0);
    check("R6 v overflow", muteFlag, 1);
    check("R9 nmi on v overflow", nmiReq, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule